// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock first-in first-out buffer, nine bits wide and 512 words deep by default; the width and depth are parameters. It drives four active-low status flags. Two show the end points: `empty_n` and `full_n`. Two show thresholds: `aempty_n` is low while few words are held, and `afull_n` is low while few locations are free. The read data leaves through a register. An active-low output enable releases the read data bus to high impedance.

The two thresholds come from a small bank of offset registers. The empty offset and the full offset are each held as a low word and a high word of W bits, and their value is `high * 2^W + low`. The second write enable doubles as a load-select line. While it is low, write cycles place `din` into the offset words instead of the buffer, and read cycles place the offset words on the output instead of buffer data. The offset words are visited in a fixed cycle, and loading and reading back share one position. Reset gives both offsets the default values and returns the position to the first word.

Two state machines run the block. The offset selector has states `SEL_EMPTY_LO`, `SEL_EMPTY_HI`, `SEL_FULL_LO` and `SEL_FULL_HI`. Each load or read-back cycle moves it to the next state in that list, and from `SEL_FULL_HI` it returns to `SEL_EMPTY_LO`. In any other cycle it stays where it is. The occupancy machine has states `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`. It makes these transitions:
- fill: `OCC_EMPTY`→`OCC_PART` on a write.
- top: `OCC_PART`→`OCC_FULL` when a lone write reaches DEPTH.
- drain: `OCC_PART`→`OCC_EMPTY` when a lone read reaches zero.
- leave-full: `OCC_FULL`→`OCC_PART` on a read.

In every other case it stays where it is. For a depth of one, fill goes straight to `OCC_FULL`, and leave-full goes straight to `OCC_EMPTY`.

Top module: `sfifo_pflag`

## Requirements
- R1: A buffer write needs `wr_en_n` low and `wr_en2_ld` high in the same cycle. A buffer read needs `rd_en_n` and `rd_en2_n` both low. If only one enable of a pair is active, neither the data nor the flags change.
- R2: While `oe_n` is high, `dout` is high impedance. While `oe_n` is low, `dout` drives the output register.
- R3: A cycle with `wr_en_n` low and `wr_en2_ld` low stores `din` into the selected offset word. The selection then advances in the order empty-low, empty-high, full-low, full-high, and after full-high it returns to empty-low.
- R4: A cycle with `wr_en2_ld` low and both read enables low loads the selected offset word into the output register. The selection then advances in the same order, and loading and read-back share one position.
- R5: Reset (`rst_n` low) sets both offsets to their defaults (7 and 7), selects empty-low, and clears the pointers, the count and the output register. After reset, `empty_n` and `aempty_n` are low and `afull_n` and `full_n` are high.
- R6: `empty_n` is low exactly when no word is held. A word written at one edge can be read at the next edge, and it appears on `dout` after that read edge.
- R7: `full_n` is low exactly when DEPTH words are held.
- R8: `aempty_n` is low while the number of words held is less than or equal to the empty offset, and high otherwise.
- R9: `afull_n` is low while the number of words held is DEPTH minus the full offset or more. It is high while more locations are free than the full offset.
- R10: A write while full and a read while empty are ignored. The stored data, the count and the output register keep their values.
- R11: A read and a write in the same cycle leave the count unchanged, and words leave in the order they entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset |
| din | input | W | Write data, or an offset word during load |
| wr_en_n | input | 1 | First write enable, active low |
| wr_en2_ld | input | 1 | Second write enable when high; selects the offset registers when low |
| rd_en_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | W | Registered read data, or high impedance |
| empty_n | output | 1 | Low when the buffer is empty |
| aempty_n | output | 1 | Low when the count is at or below the empty offset |
| afull_n | output | 1 | Low when the free space is at or below the full offset |
| full_n | output | 1 | Low when the buffer is full |

## Verification
The assertions assume that the enables are never unknown outside reset. They also assume that, after reset, the offsets are changed only by deliberate load cycles. That second assumption matters because an offset word written by accident would move a threshold while a fill is in progress. The stimulus drives every enable to a defined level from time zero. It changes inputs only on falling edges. It issues load cycles only in a directed block, while the buffer is empty. Flag thresholds are checked only after the offsets have been read back.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Position in the offset word cycle; the order is part of the behaviour.
    typedef enum logic [1:0] {
        SEL_EMPTY_LO = 2'd0,
        SEL_EMPTY_HI = 2'd1,
        SEL_FULL_LO  = 2'd2,
        SEL_FULL_HI  = 2'd3
    } ofs_sel_e;

    // Occupancy class of the buffer.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

endpackage

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
    parameter int W     = 9,
    parameter int DEPTH = 512,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = mem_q[raddr];
    end

endmodule

// File: rtl/sfifo_ofs_bank.sv
module sfifo_ofs_bank
    import sfifo_pkg::*;
#(
    parameter int W             = 9,
    parameter int DEF_EMPTY_OFS = 7,
    parameter int DEF_FULL_OFS  = 7,
    localparam int OW           = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_go,
    input  logic          peek_go,
    input  logic [W-1:0]  din,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs,
    output logic [W-1:0]  peek_word
);

    localparam logic [OW-1:0] DEF_E = OW'(DEF_EMPTY_OFS);
    localparam logic [OW-1:0] DEF_F = OW'(DEF_FULL_OFS);

    ofs_sel_e     sel_q, sel_nx;
    logic [W-1:0] word_q [4];
    logic         step;

    assign step = load_go || peek_go;

    // Next selection: each load or read-back cycle advances one word.
    always_comb begin
        sel_nx = sel_q;
        if (step) begin
            unique case (sel_q)
                SEL_EMPTY_LO: sel_nx = SEL_EMPTY_HI;
                SEL_EMPTY_HI: sel_nx = SEL_FULL_LO;
                SEL_FULL_LO:  sel_nx = SEL_FULL_HI;
                SEL_FULL_HI:  sel_nx = SEL_EMPTY_LO;
                default:      sel_nx = SEL_EMPTY_LO;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_EMPTY_LO;
        end else begin
            sel_q <= sel_nx;
        end
    end

    // Offset words.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q[0] <= DEF_E[W-1:0];
            word_q[1] <= DEF_E[OW-1:W];
            word_q[2] <= DEF_F[W-1:0];
            word_q[3] <= DEF_F[OW-1:W];
        end else if (load_go) begin
            word_q[sel_q] <= din;
        end
    end

    // Outputs.
    always_comb begin
        empty_ofs = {word_q[1], word_q[0]};
        full_ofs  = {word_q[3], word_q[2]};
        peek_word = word_q[sel_q];
    end

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sel_q == SEL_FULL_HI) |=> (sel_q == SEL_EMPTY_LO));

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sel_q == SEL_EMPTY_LO) |=> (sel_q == SEL_EMPTY_HI));

    a_r3_empty_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_go && sel_q == SEL_EMPTY_LO) |=> (empty_ofs[W-1:0] == $past(din)));

    a_r4_hold_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sel_q));

    a_r4_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_go && !load_go) |=> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

// File: rtl/sfifo_occ_ctrl.sv
module sfifo_occ_ctrl
    import sfifo_pkg::*;
#(
    parameter int W     = 9,
    parameter int DEPTH = 512,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int OW   = 2 * W,
    localparam int XW   = ((CW > OW) ? CW : OW) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [OW-1:0] empty_ofs,
    input  logic [OW-1:0] full_ofs,
    output logic          wr_go,
    output logic          rd_go,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          afull_n,
    output logic          full_n
);

    occ_e          st_q, st_nx;
    logic [CW-1:0] cnt_q, cnt_nx;
    logic [XW-1:0] cnt_x;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_go = wr_req && (st_q != OCC_FULL);
    assign rd_go = rd_req && (st_q != OCC_EMPTY);

    always_comb begin
        cnt_nx = cnt_q;
        if (wr_go && !rd_go) begin
            cnt_nx = cnt_q + 1'b1;
        end else if (rd_go && !wr_go) begin
            cnt_nx = cnt_q - 1'b1;
        end
    end

    // Occupancy transitions: fill, top, drain, leave-full.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            OCC_EMPTY: if (wr_go) begin
                st_nx = (cnt_nx == CW'(DEPTH)) ? OCC_FULL : OCC_PART;
            end
            OCC_PART: if (wr_go != rd_go) begin
                if (cnt_nx == '0) begin
                    st_nx = OCC_EMPTY;
                end else if (cnt_nx == CW'(DEPTH)) begin
                    st_nx = OCC_FULL;
                end
            end
            OCC_FULL: if (rd_go) begin
                st_nx = (cnt_nx == '0) ? OCC_EMPTY : OCC_PART;
            end
            default: st_nx = OCC_EMPTY;
        endcase
    end

    // State register with count and pointers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= OCC_EMPTY;
            cnt_q <= '0;
            wptr  <= '0;
            rptr  <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
            if (wr_go) begin
                wptr <= bump(wptr);
            end
            if (rd_go) begin
                rptr <= bump(rptr);
            end
        end
    end

    // Flag outputs.
    always_comb begin
        cnt_x    = XW'(cnt_q);
        empty_n  = (st_q != OCC_EMPTY);
        full_n   = (st_q != OCC_FULL);
        aempty_n = (cnt_x > XW'(empty_ofs));
        afull_n  = ((cnt_x + XW'(full_ofs)) < XW'(DEPTH));
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    a_r6_empty_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OCC_EMPTY) == (cnt_q == '0));

    a_r7_full_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OCC_FULL) == (cnt_q == CW'(DEPTH)));

    a_r10_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OCC_FULL && wr_req && !rd_req) |=> ($stable(wptr) && $stable(cnt_q)));

    a_r10_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OCC_EMPTY && rd_req && !wr_req) |=> ($stable(rptr) && $stable(cnt_q)));

    a_r11_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && rd_go) |=> $stable(cnt_q));

endmodule

// File: rtl/sfifo_pflag.sv
module sfifo_pflag #(
    parameter int W             = 9,
    parameter int DEPTH         = 512,
    parameter int DEF_EMPTY_OFS = 7,
    parameter int DEF_FULL_OFS  = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         wr_en_n,
    input  logic         wr_en2_ld,
    input  logic         rd_en_n,
    input  logic         rd_en2_n,
    input  logic         oe_n,
    output logic [W-1:0] dout,
    output logic         empty_n,
    output logic         aempty_n,
    output logic         afull_n,
    output logic         full_n
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = 2 * W;

    logic          load_go, wr_req, rd_both, peek_go, rd_req;
    logic          wr_go, rd_go;
    logic [PW-1:0] wptr, rptr;
    logic [W-1:0]  ram_rd, peek_word, q_q;
    logic [OW-1:0] empty_ofs, full_ofs;

    assign load_go = !wr_en_n && !wr_en2_ld;
    assign wr_req  = !wr_en_n &&  wr_en2_ld;
    assign rd_both = !rd_en_n && !rd_en2_n;
    assign peek_go = rd_both && !wr_en2_ld;
    assign rd_req  = rd_both &&  wr_en2_ld;

    sfifo_ofs_bank #(
        .W             (W),
        .DEF_EMPTY_OFS (DEF_EMPTY_OFS),
        .DEF_FULL_OFS  (DEF_FULL_OFS)
    ) u_ofs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_go   (load_go),
        .peek_go   (peek_go),
        .din       (din),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .peek_word (peek_word)
    );

    sfifo_occ_ctrl #(
        .W     (W),
        .DEPTH (DEPTH)
    ) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .wptr      (wptr),
        .rptr      (rptr),
        .empty_n   (empty_n),
        .aempty_n  (aempty_n),
        .afull_n   (afull_n),
        .full_n    (full_n)
    );

    sfifo_ram #(
        .W     (W),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wptr),
        .wdata (din),
        .raddr (rptr),
        .rdata (ram_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else if (rd_go) begin
            q_q <= ram_rd;
        end else if (peek_go) begin
            q_q <= peek_word;
        end
    end

    assign dout = oe_n ? {W{1'bz}} : q_q;

    a_r1_half_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_n || rd_en2_n) |=> $stable(q_q));

    a_r10_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_req) |=> $stable(q_q));

endmodule

// File: tb/sim_sfifo_pflag.sv
module sim_sfifo_pflag;

    localparam int W     = 9;
    localparam int DEPTH = 512;

    typedef struct packed {
        logic         wn;
        logic         w2;
        logic         rn;
        logic         r2n;
        logic [W-1:0] d;
        logic [W-1:0] q;
        logic [3:0]   f;  // {empty_n, aempty_n, afull_n, full_n}
    } vec_t;

    // Applied from reset; defaults 7/7 for both offsets.
    localparam vec_t VT [13] = '{
        '{1'b1, 1'b1, 1'b1, 1'b1, 9'h0AA, 9'h000, 4'b0011}, // R1 idle
        '{1'b0, 1'b1, 1'b1, 1'b1, 9'h011, 9'h000, 4'b1011}, // R6 write
        '{1'b1, 1'b1, 1'b0, 1'b1, 9'h000, 9'h000, 4'b1011}, // R1 one read enable
        '{1'b1, 1'b1, 1'b0, 1'b0, 9'h000, 9'h011, 4'b0011}, // R6 read
        '{1'b1, 1'b1, 1'b0, 1'b0, 9'h000, 9'h011, 4'b0011}, // R10 read empty
        '{1'b0, 1'b1, 1'b0, 1'b0, 9'h022, 9'h011, 4'b1011}, // R10 both at empty
        '{1'b0, 1'b1, 1'b0, 1'b0, 9'h033, 9'h022, 4'b1011}, // R11 both
        '{1'b1, 1'b1, 1'b0, 1'b0, 9'h000, 9'h033, 4'b0011}, // R11 order
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 9'h007, 4'b0011}, // R4 empty lo
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 9'h000, 4'b0011}, // R4 empty hi
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 9'h007, 4'b0011}, // R4 full lo
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 9'h000, 4'b0011}, // R4 full hi
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 9'h007, 4'b0011}  // R4 wrap
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic         wr_en_n = 1'b1, wr_en2_ld = 1'b1, rd_en_n = 1'b1, rd_en2_n = 1'b1;
    logic         oe_n = 1'b0;
    logic [W-1:0] dout;
    logic         empty_n, aempty_n, afull_n, full_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sfifo_pflag #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .wr_en_n   (wr_en_n),
        .wr_en2_ld (wr_en2_ld),
        .rd_en_n   (rd_en_n),
        .rd_en2_n  (rd_en2_n),
        .oe_n      (oe_n),
        .dout      (dout),
        .empty_n   (empty_n),
        .aempty_n  (aempty_n),
        .afull_n   (afull_n),
        .full_n    (full_n)
    );

    function automatic logic [W-1:0] pat(input int i);
        return W'((i * 37 + 5) % 512);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Drive on a falling edge, return at the next falling edge.
    task automatic step(input logic wn, input logic w2, input logic rn,
                        input logic r2n, input logic [W-1:0] d);
        wr_en_n = wn; wr_en2_ld = w2; rd_en_n = rn; rd_en2_n = r2n; din = d;
        @(negedge clk);
        wr_en_n = 1'b1; wr_en2_ld = 1'b1; rd_en_n = 1'b1; rd_en2_n = 1'b1;
    endtask

    function automatic logic [3:0] flags();
        return {empty_n, aempty_n, afull_n, full_n};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        report();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset flags", 32'(flags()), 32'b0011);
        chk("R5 reset dout", 32'(dout), 32'h0);

        foreach (VT[i]) begin
            step(VT[i].wn, VT[i].w2, VT[i].rn, VT[i].r2n, VT[i].d);
            chk($sformatf("table %0d dout (R1 R4 R6 R10 R11)", i), 32'(dout), 32'(VT[i].q));
            chk($sformatf("table %0d flags (R1 R6 R8)", i), 32'(flags()), 32'(VT[i].f));
        end

        // R5: reset mid-cycle restores defaults and selection.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 flags after reset", 32'(flags()), 32'b0011);
        chk("R5 dout after reset", 32'(dout), 32'h0);
        step(1, 0, 0, 0, 0); chk("R5 default empty lo", 32'(dout), 32'h7);
        step(1, 0, 0, 0, 0); chk("R5 default empty hi", 32'(dout), 32'h0);
        step(1, 0, 0, 0, 0); chk("R5 default full lo", 32'(dout), 32'h7);
        step(1, 0, 0, 0, 0); chk("R5 default full hi", 32'(dout), 32'h0);

        // R3: five loads wrap onto empty-lo; selection now at empty-hi.
        step(0, 0, 1, 1, 9'd2);
        step(0, 0, 1, 1, 9'd0);
        step(0, 0, 1, 1, 9'd4);
        step(0, 0, 1, 1, 9'd0);
        step(0, 0, 1, 1, 9'd9);
        chk("R3 load leaves buffer empty", 32'(flags()), 32'b0011);
        step(1, 0, 0, 0, 0); chk("R3 R4 empty hi", 32'(dout), 32'h0);
        step(1, 0, 0, 0, 0); chk("R3 R4 full lo", 32'(dout), 32'h4);
        step(1, 0, 0, 0, 0); chk("R3 R4 full hi", 32'(dout), 32'h0);
        step(1, 0, 0, 0, 0); chk("R3 wrap empty lo", 32'(dout), 32'h9);

        // Fill: empty offset 9, full offset 4.
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 1, 1, 1, pat(i));
            if (i + 1 == 1)   chk("R6 not empty", 32'(empty_n), 32'd1);
            if (i + 1 == 9)   chk("R8 at offset", 32'(aempty_n), 32'd0);
            if (i + 1 == 10)  chk("R8 above offset", 32'(aempty_n), 32'd1);
            if (i + 1 == 507) chk("R9 free five", 32'(afull_n), 32'd1);
            if (i + 1 == 508) chk("R9 free four", 32'(afull_n), 32'd0);
            if (i + 1 == 511) chk("R7 one free", 32'(full_n), 32'd1);
        end
        chk("R7 full", 32'(flags()), 32'b1100);
        step(0, 1, 1, 1, 9'h1FF);
        step(0, 1, 1, 1, 9'h1FF);
        chk("R10 write full flags", 32'(flags()), 32'b1100);

        // R2: output enable.
        oe_n = 1'b1;
        #1;
        chk("R2 high impedance", 32'(dout === {W{1'bz}}), 32'd1);
        oe_n = 1'b0;
        #1;
        chk("R2 driven", 32'(dout), 32'h9);

        // Drain in order; the ignored writes must not appear.
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 1, 0, 0, 0);
            chk($sformatf("R11 R10 word %0d", i), 32'(dout), 32'(pat(i)));
            if (DEPTH - 1 - i == 508) chk("R9 drain free four", 32'(afull_n), 32'd0);
            if (DEPTH - 1 - i == 507) chk("R9 drain free five", 32'(afull_n), 32'd1);
            if (DEPTH - 1 - i == 9)   chk("R8 drain at offset", 32'(aempty_n), 32'd0);
        end
        chk("R6 drained", 32'(flags()), 32'b0011);
        step(1, 1, 0, 0, 0);
        chk("R10 read empty dout", 32'(dout), 32'(pat(DEPTH - 1)));
        chk("R10 read empty flags", 32'(flags()), 32'b0011);

        report();
        $finish;
    end

endmodule